// File: doc/BRIEF.md
# Prioritised DMA Channel Request Arbiter

This block sits in front of a single-item transfer engine and chooses which of several peripheral DMA channels is served next. Each channel presents a level request from its peripheral. The arbiter keeps a small amount of state per channel: a mode word, an error flag, and a one-item event credit. It issues one grant at a time and names the winning channel with an index. The grant stays up until the engine reports that the item is finished. When that report carries an invalid-address flag, the channel is halted and its error flag is set. Software must then load a new address and write the error-clear bit before the channel can take part in arbitration again.

In event-trigger mode a channel's request is ignored until a peripheral event grants it a credit. Each credit pays for exactly one item. A credit that arrives before any request is kept and is spent as soon as the request appears. If another event arrives while a credit is already waiting and the channel is being served, the event is reported on a per-channel overflow pulse. When the error flag of a channel is set and that channel's error interrupt is enabled, the shared interrupt line is asserted.

Register writes use a channel index, a 2-bit selector and 2 data bits. Selector 0 is the mode word: data bit 0 enables event-trigger mode and data bit 1 enables the error interrupt. Selector 1 is an address write; its data is ignored, and it only records that a fresh address is now present. Selector 2 is control: data bit 0 requests an error clear and is not stored.

Top module: `dma_req_arbiter`

## Requirements
- R1: A channel is eligible when it requests, is not halted, and, if it is in event-trigger mode, holds a credit. When the arbiter is idle and several channels are eligible, the lowest-indexed one is granted on the next clock edge.
- R2: While the engine has not reported done, `grantValid` and `grantCh` stay unchanged. On the edge where done is reported, `grantValid` falls. No new grant can be issued before the following edge.
- R3: If done is reported together with `addrErr`, `errStatus` for the granted channel is set on that edge. A halted channel is never granted, and it does not block the channels with higher indices.
- R4: A control write with data bit 0 set clears a channel's error flag only if an address write has reached that channel since the error was set. Otherwise the write is ignored.
- R5: If a clear and a new error for the same channel occur in the same cycle, the error flag ends up set.
- R6: `irq` is high exactly when some channel has its error flag set and its error interrupt enabled (mode data bit 1).
- R7: A channel in event-trigger mode (mode data bit 0) that holds no credit is not granted, even while it requests.
- R8: Each event credit allows exactly one grant. After that grant completes, the channel is not granted again until a new event arrives.
- R9: An event that arrives while the channel is not requesting is kept as a credit. The channel is granted as soon as its request appears.
- R10: An event that arrives for a channel that already holds a credit while that channel is being served produces a one-cycle `evtOverflow` pulse for that channel on the next edge.
- R11: After reset there is no grant, and all error flags, the interrupt, the overflow pulses and the modes are zero.
- R12: Events that arrive while a channel is not in event-trigger mode leave no credit behind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chReq | input | NUM_CH | Per-channel peripheral request level |
| chEvent | input | NUM_CH | Per-channel peripheral event pulse |
| xferDone | input | 1 | Engine finished the granted item |
| addrErr | input | 1 | Finished item hit an invalid address (valid with xferDone) |
| regWrEn | input | 1 | Register write strobe |
| regWrCh | input | IDX_W | Channel targeted by the write |
| regWrSel | input | 2 | 0 mode, 1 address, 2 control |
| regWrData | input | 2 | Write data |
| grantValid | output | 1 | A grant is outstanding |
| grantCh | output | IDX_W | Index of the granted channel |
| errStatus | output | NUM_CH | Per-channel transfer-error flag |
| irq | output | 1 | Transfer-error interrupt request |
| evtOverflow | output | NUM_CH | Per-channel event-overflow pulse |

## Verification
Directed patterns check the following cases: contention among several requesters, which tests lowest-index priority; a halted high-priority channel next to a requesting lower one, which shows whether a halted channel blocks the others; and a clear issued with and without a fresh address, and in the same cycle as a new error, which separates the three possible clear outcomes. Event patterns cover an event before the request, a request with no event, and repeated events while the channel is busy. These distinguish a remembered credit, gating, one-item consumption and overflow. A long random phase then mixes requests, events, completions, address faults and register writes, and compares the block each cycle against a behavioural model kept in the bench.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  typedef enum logic {ARB_IDLE, ARB_BUSY} arbState_e;

  // Strobes passed from the control to the channel datapath
  typedef struct packed {
    logic busy;    // a grant is outstanding
    logic issue;   // a grant is issued this cycle to pickCh
    logic finish;  // the outstanding grant completes this cycle
    logic fault;   // the completing item hit an invalid address
  } arbStrobe_t;

  localparam logic [1:0] SEL_MODE = 2'd0;
  localparam logic [1:0] SEL_ADDR = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;

endpackage

// File: rtl/dma_arb_ctrl.sv
module dma_arb_ctrl
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] eligible,
  input  logic              xferDone,
  input  logic              addrErr,
  output arbStrobe_t        strobe,
  output logic [IDX_W-1:0]  pickCh,
  output logic              grantValid,
  output logic [IDX_W-1:0]  grantCh
);

  arbState_e state;
  logic      anyEligible;

  // Fixed priority: the lowest index wins
  always_comb begin
    pickCh = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (eligible[i]) pickCh = IDX_W'(i);
    end
  end

  assign anyEligible   = |eligible;
  assign strobe.busy   = (state == ARB_BUSY);
  assign strobe.issue  = (state == ARB_IDLE) && anyEligible;
  assign strobe.finish = (state == ARB_BUSY) && xferDone;
  assign strobe.fault  = strobe.finish && addrErr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ARB_IDLE;
      grantCh <= '0;
    end else begin
      if (strobe.issue) begin
        state   <= ARB_BUSY;
        grantCh <= pickCh;
      end else if (strobe.finish) begin
        state <= ARB_IDLE;
      end
    end
  end

  assign grantValid = (state == ARB_BUSY);

endmodule

// File: rtl/dma_arb_datapath.sv
module dma_arb_datapath
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] chReq,
  input  logic [NUM_CH-1:0] chEvent,
  input  logic              regWrEn,
  input  logic [IDX_W-1:0]  regWrCh,
  input  logic [1:0]        regWrSel,
  input  logic [1:0]        regWrData,
  input  arbStrobe_t        strobe,
  input  logic [IDX_W-1:0]  pickCh,
  input  logic [IDX_W-1:0]  activeCh,
  output logic [NUM_CH-1:0] eligible,
  output logic [NUM_CH-1:0] errStatus,
  output logic              irq,
  output logic [NUM_CH-1:0] evtOverflow
);

  logic [NUM_CH-1:0] evtMode;
  logic [NUM_CH-1:0] irqEn;
  logic [NUM_CH-1:0] addrFresh;
  logic [NUM_CH-1:0] credit;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    logic wrHit, isActive, consume, errSet, errClr;

    assign wrHit    = regWrEn && (regWrCh == IDX_W'(g));
    assign isActive = strobe.busy && (activeCh == IDX_W'(g));
    assign consume  = strobe.issue && (pickCh == IDX_W'(g)) && evtMode[g];
    assign errSet   = strobe.fault && (activeCh == IDX_W'(g));
    assign errClr   = wrHit && (regWrSel == SEL_CTRL) && regWrData[0] && addrFresh[g];

    assign eligible[g] = chReq[g] && !errStatus[g] && (!evtMode[g] || credit[g]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        evtMode[g]     <= 1'b0;
        irqEn[g]       <= 1'b0;
        addrFresh[g]   <= 1'b0;
        errStatus[g]   <= 1'b0;
        credit[g]      <= 1'b0;
        evtOverflow[g] <= 1'b0;
      end else begin
        if (wrHit && regWrSel == SEL_MODE) begin
          evtMode[g] <= regWrData[0];
          irqEn[g]   <= regWrData[1];
        end
        // A new fault takes precedence over a clear and a fresh address
        if (errSet) begin
          errStatus[g] <= 1'b1;
          addrFresh[g] <= 1'b0;
        end else begin
          if (errClr) errStatus[g] <= 1'b0;
          if (wrHit && regWrSel == SEL_ADDR) addrFresh[g] <= 1'b1;
        end
        if (evtMode[g]) credit[g] <= (credit[g] && !consume) || chEvent[g];
        else            credit[g] <= 1'b0;
        evtOverflow[g] <= chEvent[g] && credit[g] && isActive && evtMode[g];
      end
    end
  end

  assign irq = |(errStatus & irqEn);

endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] chReq,
  input  logic [NUM_CH-1:0] chEvent,
  input  logic              xferDone,
  input  logic              addrErr,
  input  logic              regWrEn,
  input  logic [IDX_W-1:0]  regWrCh,
  input  logic [1:0]        regWrSel,
  input  logic [1:0]        regWrData,
  output logic              grantValid,
  output logic [IDX_W-1:0]  grantCh,
  output logic [NUM_CH-1:0] errStatus,
  output logic              irq,
  output logic [NUM_CH-1:0] evtOverflow
);

  arbStrobe_t        strobe;
  logic [NUM_CH-1:0] eligible;
  logic [IDX_W-1:0]  pickCh;

  dma_arb_ctrl #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .eligible   (eligible),
    .xferDone   (xferDone),
    .addrErr    (addrErr),
    .strobe     (strobe),
    .pickCh     (pickCh),
    .grantValid (grantValid),
    .grantCh    (grantCh)
  );

  dma_arb_datapath #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .chReq       (chReq),
    .chEvent     (chEvent),
    .regWrEn     (regWrEn),
    .regWrCh     (regWrCh),
    .regWrSel    (regWrSel),
    .regWrData   (regWrData),
    .strobe      (strobe),
    .pickCh      (pickCh),
    .activeCh    (grantCh),
    .eligible    (eligible),
    .errStatus   (errStatus),
    .irq         (irq),
    .evtOverflow (evtOverflow)
  );

endmodule

// File: rtl/dma_arb_checker.sv
module dma_arb_checker #(
  parameter int NUM_CH = 4,
  parameter int IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] chReq,
  input logic              xferDone,
  input logic              addrErr,
  input logic              grantValid,
  input logic [IDX_W-1:0]  grantCh,
  input logic [NUM_CH-1:0] errStatus,
  input logic              irq,
  input logic [NUM_CH-1:0] evtOverflow
);

  logic [NUM_CH-1:0] activeOh;
  assign activeOh = grantValid ? (NUM_CH'(1) << grantCh) : '0;

  assert_grant_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    grantValid && !xferDone |=> grantValid && $stable(grantCh));

  assert_grant_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    grantValid && xferDone |=> !grantValid);

  assert_grant_to_requester_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grantValid) |-> |($past(chReq) & activeOh));

  assert_fault_sets_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    grantValid && xferDone && addrErr |=> |(errStatus & $past(activeOh)));

  assert_halted_not_granted_R3: assert property (@(posedge clk) disable iff (!rst_n)
    grantValid |-> (errStatus & activeOh) == '0);

  assert_irq_needs_error_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> |errStatus);

  assert_overflow_while_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    |evtOverflow |-> $past(grantValid) && $onehot0(evtOverflow));

endmodule

bind dma_req_arbiter dma_arb_checker #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .chReq       (chReq),
  .xferDone    (xferDone),
  .addrErr     (addrErr),
  .grantValid  (grantValid),
  .grantCh     (grantCh),
  .errStatus   (errStatus),
  .irq         (irq),
  .evtOverflow (evtOverflow)
);

// File: tb/dma_req_arbiter_tb.sv
module dma_req_arbiter_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] req = '0, evt = '0;
  logic       done = 1'b0, aerr = 1'b0, wrEn = 1'b0;
  logic [1:0] wrCh = '0, wrSel = '0, wrData = '0;
  logic       grantValid, irq;
  logic [1:0] grantCh;
  logic [3:0] errStatus, evtOverflow;

  int checks = 0;
  int fails  = 0;

  // Reference state
  logic       mGv;
  logic [1:0] mCh;
  logic [3:0] mErr, mFresh, mEvt, mIrqEn, mCredit, mOvf;

  always #2 clk = ~clk;

  dma_req_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .chReq(req), .chEvent(evt),
    .xferDone(done), .addrErr(aerr), .regWrEn(wrEn), .regWrCh(wrCh),
    .regWrSel(wrSel), .regWrData(wrData), .grantValid(grantValid),
    .grantCh(grantCh), .errStatus(errStatus), .irq(irq),
    .evtOverflow(evtOverflow)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] lowest(input logic [3:0] v);
    logic [1:0] p = '0;
    for (int i = 3; i >= 0; i--) if (v[i]) p = 2'(i);
    return p;
  endfunction

  // One clock: evaluate the model on the pre-edge inputs, then compare after the edge
  task automatic step();
    logic [3:0] elig, nErr, nFresh, nEvt, nIrq, nCredit, nOvf;
    logic issue, finish, fault, nGv;
    logic [1:0] pick, nCh;
    @(negedge clk);
    elig   = req & ~mErr & (~mEvt | mCredit);
    issue  = !mGv && (elig != 0);
    pick   = lowest(elig);
    finish = mGv && done;
    fault  = finish && aerr;
    nErr = mErr; nFresh = mFresh; nEvt = mEvt; nIrq = mIrqEn;
    for (int i = 0; i < 4; i++) begin
      bit wr, busyI, consume, errSet;
      wr      = wrEn && wrCh == 2'(i);
      busyI   = mGv && mCh == 2'(i);
      consume = issue && pick == 2'(i) && mEvt[i];
      errSet  = fault && mCh == 2'(i);
      nOvf[i]    = evt[i] && mCredit[i] && busyI && mEvt[i];
      nCredit[i] = mEvt[i] ? ((mCredit[i] && !consume) || evt[i]) : 1'b0;
      if (wr && wrSel == 2'd0) begin nEvt[i] = wrData[0]; nIrq[i] = wrData[1]; end
      if (errSet) begin nErr[i] = 1'b1; nFresh[i] = 1'b0; end
      else begin
        if (wr && wrSel == 2'd2 && wrData[0] && mFresh[i]) nErr[i] = 1'b0;
        if (wr && wrSel == 2'd1) nFresh[i] = 1'b1;
      end
    end
    nGv = issue ? 1'b1 : (finish ? 1'b0 : mGv);
    nCh = issue ? pick : mCh;
    @(posedge clk);
    #1;
    mGv = nGv; mCh = nCh; mErr = nErr; mFresh = nFresh; mEvt = nEvt;
    mIrqEn = nIrq; mCredit = nCredit; mOvf = nOvf;
    chk(grantValid == mGv && (!mGv || grantCh == mCh), "R1 R2 grant",
        {grantValid, grantCh}, {mGv, mCh});
    chk(errStatus == mErr, "R3 R4 R5 errStatus", errStatus, mErr);
    chk(irq == |(mErr & mIrqEn), "R6 irq", irq, |(mErr & mIrqEn));
    chk(evtOverflow == mOvf, "R10 evtOverflow", evtOverflow, mOvf);
    evt = '0; done = 1'b0; aerr = 1'b0; wrEn = 1'b0;
  endtask

  task automatic regWrite(input logic [1:0] ch, input logic [1:0] sel, input logic [1:0] d);
    wrEn = 1'b1; wrCh = ch; wrSel = sel; wrData = d;
    step();
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog expired, actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4021));
    mGv = 0; mCh = 0; mErr = 0; mFresh = 0; mEvt = 0; mIrqEn = 0; mCredit = 0; mOvf = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk(!grantValid && errStatus == 0 && !irq && evtOverflow == 0, "R11 reset",
        {grantValid, errStatus, irq, evtOverflow}, 0);

    // R1 priority among contenders, R2 hold and release
    req = 4'b1100; step();
    chk(grantValid && grantCh == 2, "R1 lowest wins", grantCh, 2);
    step();
    chk(grantValid && grantCh == 2, "R2 held", grantCh, 2);
    done = 1; step();
    chk(!grantValid, "R2 released", grantValid, 0);
    step();
    chk(grantValid && grantCh == 2, "R2 regrant", grantCh, 2);

    // R3 fault halts channel 2, channel 3 still served; R6 interrupt
    done = 1; aerr = 1; step();
    chk(errStatus[2], "R3 flag set", errStatus, 4'b0100);
    step();
    chk(grantValid && grantCh == 3, "R3 halted does not block", grantCh, 3);
    regWrite(2, 2'd0, 2'b10);
    chk(irq, "R6 irq on", irq, 1);

    // R4 clear ignored without a fresh address, accepted with one
    regWrite(2, 2'd2, 2'b01);
    chk(errStatus[2], "R4 clear ignored", errStatus[2], 1);
    regWrite(2, 2'd1, 2'b00);
    regWrite(2, 2'd2, 2'b01);
    chk(!errStatus[2] && !irq, "R4 R6 cleared", {errStatus[2], irq}, 0);

    // R5 clear and new fault in the same cycle
    req = 4'b0100; done = 1; step();
    step();
    chk(grantValid && grantCh == 2, "R5 setup grant", grantCh, 2);
    regWrite(2, 2'd1, 2'b00);
    done = 1; aerr = 1; wrEn = 1; wrCh = 2; wrSel = 2'd2; wrData = 2'b01; step();
    chk(errStatus[2], "R5 fault wins", errStatus[2], 1);
    req = 4'b0000;
    regWrite(2, 2'd1, 2'b00);
    regWrite(2, 2'd2, 2'b01);

    // R7 gating, R9 remembered event, R8 one item per event
    regWrite(1, 2'd0, 2'b01);
    req = 4'b0010; step(); step();
    chk(!grantValid, "R7 blocked without event", grantValid, 0);
    req = 4'b0000; evt = 4'b0010; step();
    req = 4'b0010; step();
    chk(grantValid && grantCh == 1, "R9 stored event", grantCh, 1);
    done = 1; step(); step(); step();
    chk(!grantValid, "R8 one item per event", grantValid, 0);

    // R10 overflow while busy
    evt = 4'b0010; step();
    step();
    chk(grantValid && grantCh == 1, "R10 setup grant", grantCh, 1);
    evt = 4'b0010; step();
    chk(evtOverflow == 0, "R10 first event stored", evtOverflow, 0);
    evt = 4'b0010; step();
    chk(evtOverflow == 4'b0010, "R10 overflow pulse", evtOverflow, 4'b0010);
    step();
    chk(evtOverflow == 0, "R10 pulse ends", evtOverflow, 0);
    req = 4'b0000; done = 1; step();

    // R12 event outside trigger mode leaves no credit
    evt = 4'b0001; step();
    regWrite(0, 2'd0, 2'b01);
    req = 4'b0001; step(); step();
    chk(!grantValid, "R12 no stale credit", grantValid, 0);

    // Random phase
    for (int n = 0; n < 4000; n++) begin
      if (n % 8 == 0) req = 4'($urandom);
      for (int i = 0; i < 4; i++) evt[i] = ($urandom % 10) == 0;
      if (mGv && ($urandom % 3) == 0) begin
        done = 1'b1;
        aerr = ($urandom % 5) == 0;
      end
      if (($urandom % 6) == 0) begin
        wrEn = 1'b1; wrCh = 2'($urandom); wrSel = 2'($urandom % 3); wrData = 2'($urandom);
      end
      step();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule